// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block turns a fast reference clock into the pacing pulses that a serial transmitter needs. A host loads a 16-bit divisor one byte at a time through an 8-bit write port, with separate write strobes for the upper and lower byte. An optional divide-by-4 prescaler sits in front of the divisor counter. The output `tick` fires once for every `divisor x prescale` reference clocks. A second output, `bit_strobe`, marks each full serial bit: it comes every 16 ticks in 16x oversampling mode and every 8 ticks in 8x mode.

For a target bit rate the divisor is `(f_ref / prescale) / (rate x 16)` in 16x mode and `(f_ref / prescale) / (rate x 8)` in 8x mode. With a 14.7456 MHz reference and no prescaler, divisor 96 gives 9600 bit/s and divisor 24 gives 38400 bit/s. Divisor 1 gives 921.6k without the prescaler and 230.4k with it.

A small state machine sequences the counters. Reset enters `ST_STOP`. Any divisor byte write moves every state to `ST_RELOAD`, where all counters are held at zero for one clock. From `ST_RELOAD` the machine goes to `ST_COUNT` if the divisor is non-zero, or to `ST_STOP` if it is zero. `ST_COUNT` holds until the next write. `ST_STOP` holds until a write.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick` and `bit_strobe` are low, the divisor is 0 and the block is stopped.
- R2: A write with `div_hi_we` loads `wr_data` into divisor bits 15:8. A write with `div_lo_we` loads `wr_data` into bits 7:0. The other byte keeps its value.
- R3: While the divisor is 0, `tick` never rises.
- R4: With `presc_en` low, consecutive ticks are exactly `divisor` reference clocks apart.
- R5: With `presc_en` high, consecutive ticks are exactly `4 x divisor` reference clocks apart.
- R6: When the tick period is 2 or more clocks, `tick` is high for exactly one reference clock.
- R7: A divisor byte write restarts all counting. `tick` and `bit_strobe` are low on the two clocks after the write. The first tick appears `1 + divisor x prescale` clocks after the write edge.
- R8: With `mode_16x` high (16x mode), `bit_strobe` fires on every 16th tick.
- R9: With `mode_16x` low (8x mode), `bit_strobe` fires on every 8th tick.
- R10: `bit_strobe` is only ever high in a cycle in which `tick` is high.
- R11: A change of `mode_16x` clears the tick count. `bit_strobe` is low in that cycle, and the next strobe follows a full 16 or 8 ticks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_hi_we | input | 1 | Write strobe for divisor upper byte |
| div_lo_we | input | 1 | Write strobe for divisor lower byte |
| wr_data | input | 8 | Byte written into the divisor |
| presc_en | input | 1 | 1 = divide reference by 4 before the divisor, 0 = by 1 |
| mode_16x | input | 1 | 1 = 16 ticks per bit, 0 = 8 ticks per bit |
| tick | output | 1 | One-clock oversampling tick |
| bit_strobe | output | 1 | One-clock strobe marking a bit period |

## Verification
Divisor values 0, 2, 3, 4, 5 and 258 are tried.
- Divisor 258 can only come out right if the two bytes land in separate halves.
- Divisor 0 tells a stopped counter from one that wraps.
- Divisors 3 and 5, run with and without the prescaler, separate a ×4 period from a ×1 period and expose off-by-one reload errors.
- Divisor 2 is run in both oversampling modes to separate a 16-tick bit from an 8-tick bit.
- A mode flip three ticks after a strobe tells a restarted tick count (32 clocks to the next strobe) from one that carries on.
- Rewriting the divisor while it is running confirms that the new period starts cleanly from the write.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_STOP   = 2'd0,
        ST_RELOAD = 2'd1,
        ST_COUNT  = 2'd2
    } btg_state_e;

endpackage

// File: rtl/btg_divisor_regs.sv
module btg_divisor_regs
    import baud_tick_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic              load
);

    localparam int HI_W = DIV_W - BYTE_W;

    // Either byte write triggers a restart of the counting chain.
    assign load = hi_we | lo_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            if (hi_we) div_q[DIV_W-1:BYTE_W] <= wr_data[HI_W-1:0];
            if (lo_we) div_q[BYTE_W-1:0]     <= wr_data;
        end
    end

endmodule

// File: rtl/btg_prescaler.sv
module btg_prescaler #(
    parameter int PRESC_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic presc_en,
    output logic step
);

    localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESC_DIV - 1);

    logic [PW-1:0] pre_q;
    logic          pre_wrap;

    assign pre_wrap = (pre_q == PRE_LAST);
    // Bypassed prescaler steps every clock; enabled one steps on wrap.
    assign step     = run && (!presc_en || pre_wrap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || !presc_en || pre_wrap) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/btg_divider.sv
module btg_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] div_q,
    output logic             hit
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] term;

    assign term = div_q - DIV_W'(1);
    assign hit  = step && (cnt_q == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || hit) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/btg_oversample.sv
module btg_oversample #(
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hit,
    input  logic mode_16x,
    output logic mode_chg,
    output logic strobe_q
);

    localparam int OW = $clog2(OVS_HI);
    localparam logic [OW-1:0] LAST_HI = OW'(OVS_HI - 1);
    localparam logic [OW-1:0] LAST_LO = OW'(OVS_LO - 1);

    logic [OW-1:0] ovs_q;
    logic          mode_q;
    logic          at_last;

    assign mode_chg = (mode_16x != mode_q);
    assign at_last  = (ovs_q == (mode_16x ? LAST_HI : LAST_LO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b1;
        end else begin
            mode_q <= mode_16x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovs_q    <= '0;
            strobe_q <= 1'b0;
        end else if (!run || mode_chg) begin
            ovs_q    <= '0;
            strobe_q <= 1'b0;
        end else if (hit) begin
            ovs_q    <= at_last ? '0 : ovs_q + 1'b1;
            strobe_q <= at_last;
        end else begin
            strobe_q <= 1'b0;
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int PRESC_DIV = 4,
    parameter int OVS_HI    = 16,
    parameter int OVS_LO    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        div_hi_we,
    input  logic        div_lo_we,
    input  logic [7:0]  wr_data,
    input  logic        presc_en,
    input  logic        mode_16x,
    output logic        tick,
    output logic        bit_strobe
);

    btg_state_e       state_q;
    btg_state_e       state_d;
    logic [DIV_W-1:0] div_q;
    logic             load;
    logic             run;
    logic             step;
    logic             hit;
    logic             mode_chg;
    logic             tick_q;

    btg_divisor_regs #(.DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_we   (div_hi_we),
        .lo_we   (div_lo_we),
        .wr_data (wr_data),
        .div_q   (div_q),
        .load    (load)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:   state_d = load ? ST_RELOAD : ST_STOP;
            ST_RELOAD: begin
                if (load)             state_d = ST_RELOAD;
                else if (div_q != '0) state_d = ST_COUNT;
                else                  state_d = ST_STOP;
            end
            ST_COUNT:  state_d = load ? ST_RELOAD : ST_COUNT;
            default:   state_d = ST_STOP;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        run = (state_q == ST_COUNT) && !load;
    end

    btg_prescaler #(.PRESC_DIV(PRESC_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .presc_en (presc_en),
        .step     (step)
    );

    btg_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (step),
        .div_q (div_q),
        .hit   (hit)
    );

    btg_oversample #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_ovs (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .hit      (hit),
        .mode_16x (mode_16x),
        .mode_chg (mode_chg),
        .strobe_q (bit_strobe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= run && hit;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_hi_we,
    input logic [7:0]       wr_data,
    input logic             load,
    input logic [DIV_W-1:0] div_q,
    input logic             mode_chg,
    input logic             tick,
    input logic             bit_strobe
);

    p_div_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_hi_we |=> (div_q[15:8] == $past(wr_data)));

    p_stop_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |-> !tick);

    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_q >= DIV_W'(2)) |=> !tick);

    p_reload_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!tick && !bit_strobe));

    p_strobe_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> tick);

    p_mode_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !bit_strobe);

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_hi_we  (div_hi_we),
    .wr_data    (wr_data),
    .load       (load),
    .div_q      (div_q),
    .mode_chg   (mode_chg),
    .tick       (tick),
    .bit_strobe (bit_strobe)
);

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_hi_we = 1'b0;
    logic       div_lo_we = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       presc_en = 1'b0;
    logic       mode_16x = 1'b1;
    logic       tick;
    logic       bit_strobe;

    int n_chk = 0;
    int n_err = 0;
    int tick_cnt = 0;
    int orphan_cnt = 0;
    bit done = 1'b0;

    // Reference model state
    int m_div = 0;
    int m_el = 0;
    int m_tc = 0;
    bit m_gate = 1'b0;
    bit m_counting = 1'b0;
    bit m_prev_mode = 1'b1;
    bit m_hit = 1'b0;
    bit e_tick = 1'b0;
    bit e_strobe = 1'b0;

    always #10 clk = ~clk;

    baud_tick_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_hi_we  (div_hi_we),
        .div_lo_we  (div_lo_we),
        .wr_data    (wr_data),
        .presc_en   (presc_en),
        .mode_16x   (mode_16x),
        .tick       (tick),
        .bit_strobe (bit_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model: elapsed counting clocks since restart, ticks on multiples.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_el = 0; m_tc = 0; m_gate = 0; m_counting = 0;
            m_prev_mode = 1; e_tick = 0; e_strobe = 0;
        end else begin
            e_tick = 0;
            e_strobe = 0;
            if (div_hi_we || div_lo_we) begin
                if (div_hi_we) m_div = (m_div & 255) | (int'(wr_data) << 8);
                if (div_lo_we) m_div = (m_div & 65280) | int'(wr_data);
                m_gate = 1; m_counting = 0; m_el = 0; m_tc = 0;
            end else if (m_gate) begin
                m_gate = 0; m_counting = (m_div != 0); m_el = 0; m_tc = 0;
            end else if (m_counting) begin
                m_el++;
                m_hit = ((m_el % (m_div * (presc_en ? 4 : 1))) == 0);
                e_tick = m_hit;
                if (mode_16x != m_prev_mode) begin
                    m_tc = 0;
                end else if (m_hit) begin
                    m_tc++;
                    if (m_tc == (mode_16x ? 16 : 8)) begin
                        e_strobe = 1;
                        m_tc = 0;
                    end
                end
            end
            m_prev_mode = mode_16x;
        end
    end

    // Per-cycle comparison and monitors
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tick === e_tick, "R4 R5 R6 model tick", int'(tick), int'(e_tick));
            chk(bit_strobe === e_strobe, "R8 R9 R11 model strobe", int'(bit_strobe), int'(e_strobe));
            if (tick) tick_cnt++;
            if (bit_strobe && !tick) orphan_cnt++;
        end
    end

    task automatic write_byte(input bit hi, input logic [7:0] d);
        @(negedge clk);
        div_hi_we = hi;
        div_lo_we = !hi;
        wr_data = d;
        @(negedge clk);
        div_hi_we = 1'b0;
        div_lo_we = 1'b0;
    endtask

    task automatic write_div(input int d, input bit p, input bit m);
        @(negedge clk);
        presc_en = p;
        mode_16x = m;
        write_byte(1'b1, d[15:8]);
        write_byte(1'b0, d[7:0]);
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!tick && n < 20000);
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!bit_strobe && n < 20000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int n;
        int t0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: quiet after reset
        chk(tick == 1'b0, "R1 tick after reset", int'(tick), 0);
        chk(bit_strobe == 1'b0, "R1 strobe after reset", int'(bit_strobe), 0);

        // R3: reset divisor of zero, then an explicit zero write
        t0 = tick_cnt;
        repeat (100) @(posedge clk);
        write_div(0, 1'b0, 1'b1);
        repeat (100) @(posedge clk);
        #1;
        chk(tick_cnt == t0, "R3 ticks with divisor zero", tick_cnt - t0, 0);

        // R4 / R7: divisor 5, no prescaler
        write_div(5, 1'b0, 1'b1);
        wait_tick(n);
        chk(n == 6, "R7 first tick latency div5", n, 6);
        wait_tick(n);
        chk(n == 5, "R4 tick period div5", n, 5);
        @(posedge clk); #1;
        chk(tick == 1'b0, "R6 tick one clock wide", int'(tick), 0);

        // R5: divisor 3 with prescaler
        write_div(3, 1'b1, 1'b1);
        wait_tick(n);
        chk(n == 13, "R5 first tick latency presc div3", n, 13);
        wait_tick(n);
        chk(n == 12, "R5 tick period presc div3", n, 12);

        // R2: bytes land in separate halves (258 = 0x0102)
        write_div(258, 1'b0, 1'b1);
        wait_tick(n);
        chk(n == 259, "R2 divisor 0x0102 latency", n, 259);

        // R8: 16x strobe spacing, divisor 2
        write_div(2, 1'b0, 1'b1);
        wait_strobe(n);
        chk(n == 33, "R8 first strobe 16x", n, 33);
        wait_strobe(n);
        chk(n == 32, "R8 strobe period 16x", n, 32);

        // R9: 8x strobe spacing, divisor 2
        write_div(2, 1'b0, 1'b0);
        wait_strobe(n);
        chk(n == 17, "R9 first strobe 8x", n, 17);
        wait_strobe(n);
        chk(n == 16, "R9 strobe period 8x", n, 16);

        // R11: flip mode three ticks after a strobe
        wait_tick(n);
        wait_tick(n);
        wait_tick(n);
        @(negedge clk);
        mode_16x = 1'b1;
        wait_strobe(n);
        chk(n == 32, "R11 strobe after mode change", n, 32);

        // R7: rewrite while running
        write_div(4, 1'b0, 1'b1);
        wait_tick(n);
        chk(n == 5, "R7 rewrite first tick div4", n, 5);

        repeat (50) @(posedge clk);
        #1;
        // R10: strobe never without tick
        chk(orphan_cnt == 0, "R10 strobe without tick", orphan_cnt, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule